// File: doc/BRIEF.md
# DMA Channel Interrupt and Completion Flag Bank

This block keeps two flags for each channel of a 64-channel DMA engine. One is the interrupt request and the other is the completion ("done") flag. When the engine reports that a channel has finished a transfer, the done flag is set. The interrupt flag is set at the same time, but only if that channel's completion interrupt is enabled. The interrupt flags leave the block as a 64-line request vector to an interrupt controller. Each line stays high until software clears it. The done flags are brought out on a separate status vector and never drive a request line.

Software reaches the bank through a plain address / write strobe / read strobe interface. It can clear flags in two ways:

- **Bitmap clear.** Software writes the 32-bit high or low interrupt word. Every bit written as one clears that channel's interrupt flag.
- **Clear command.** Software writes a single command byte that names one channel, or all channels. There is one such command register for interrupt flags and one for done flags.

Reads return data in the same cycle as the read strobe.

Top module: `dma_irq_status_bank`

## Requirements
- R1: The interrupt words are mapped as follows, with zero-wait combinational read data:
  - The high word is at offset 0x00. Its data bit i is channel 32+i.
  - The low word is at offset 0x04. Its data bit i is channel i.
  - Data bit 31 of the high word is therefore channel 63.
- R2: When `done_evt[c]` is high at a clock edge, the done flag of channel c is set. The interrupt flag of channel c is set at the same edge only if `done_irq_en[c]` is also high.
- R3: A write to offset 0x00 or 0x04 clears the interrupt flag of every channel whose bit is written as one. Bits written as zero leave their flags unchanged.
- R4: A write to offset 0x08 is an interrupt clear command carried in `bus_wdata[7:0]`:
  - Bit 7 is a no-operation bit. When it is one, the command does nothing.
  - When bit 7 is zero, bits 6:0 name a channel. A value from 0 to 63 clears only that channel's interrupt flag.
- R5: In a clear command with bit 7 zero, a channel field from 64 to 127 clears the flags of all 64 channels.
- R6: A write to offset 0x09 is a done clear command. It uses the same encoding as R4 and R5 and affects only done flags. The R4 command affects only interrupt flags.
- R7: The command offsets 0x08 and 0x09 read back as zero. Unmapped offsets read as zero, and writes to them change no flag.
- R8: After reset, all interrupt and done flags are zero.
- R9: If a completion set and a software clear hit the same channel in the same cycle, the flag ends set.
- R10: `irq_req` equals the interrupt flags, and each line stays high until it is cleared. Done flags alone never raise `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data; command byte in bits 7:0 |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| done_evt | input | 64 | Per-channel transfer completion pulse |
| done_irq_en | input | 64 | Per-channel completion interrupt enable |
| irq_req | output | 64 | Interrupt request lines to the controller |
| done_status | output | 64 | Per-channel done flags |

## Verification
A one-hot sweep sets and clears every channel in turn. It reads the channel back through the word that should hold it, which separates a wrong word or bit mapping from a wrong flag. Completions with the interrupt disabled distinguish the done path from the request path. Structured bitmaps such as alternating nibbles and half-words, together with zero writes, expose bits that are cleared too much or too little. Command values cover the following cases, which separate the decode branches:
- every single channel;
- the range boundaries 63, 64 and 127;
- the no-operation bit on its own and combined with other bits;
- writes to the wrong register and to an unmapped offset;
- same-cycle set and clear collisions.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned CMD_W  = 8;

    typedef struct packed {
        logic       nop;
        logic [6:0] chan;
    } clr_cmd_t;

endpackage

// File: rtl/dma_stat_flags.sv
module dma_stat_flags #(
    parameter int unsigned N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    typedef struct packed {
        logic [N-1:0] flags;
    } flag_state_t;

    flag_state_t st_d, st_q;

    // A set in the same cycle as a clear leaves the flag set.
    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

endmodule

// File: rtl/dma_stat_wdecode.sv
module dma_stat_wdecode
    import dma_stat_pkg::*;
#(
    parameter int unsigned NUM_CH  = 64,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CLR_IRQ = 8,
    parameter int unsigned CLR_DN  = 9
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [NUM_CH-1:0] clr_irq,
    output logic [NUM_CH-1:0] clr_done
);

    localparam int unsigned NUM_WORDS = NUM_CH / WORD_W;
    localparam int unsigned CH_IDX_W  = $clog2(NUM_CH);

    function automatic logic [NUM_CH-1:0] cmd_mask(input clr_cmd_t cmd);
        logic [NUM_CH-1:0] m;
        m = '0;
        if (!cmd.nop) begin
            if (int'(cmd.chan) >= int'(NUM_CH)) begin
                m = '1;
            end else begin
                m[cmd.chan[CH_IDX_W-1:0]] = 1'b1;
            end
        end
        return m;
    endfunction

    logic [NUM_CH-1:0] word_clr;
    clr_cmd_t          cmd;

    assign cmd = clr_cmd_t'(wdata[CMD_W-1:0]);

    // Word w sits at offset (NUM_WORDS-1-w)*4, so the top word is at 0.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'((NUM_WORDS - 1 - w) * 4);
        assign word_clr[w*WORD_W +: WORD_W] =
            (wr_en && addr == OFS) ? wdata : '0;
    end

    always_comb begin
        clr_irq  = word_clr;
        clr_done = '0;
        if (wr_en && addr == ADDR_W'(CLR_IRQ)) begin
            clr_irq = cmd_mask(cmd);
        end
        if (wr_en && addr == ADDR_W'(CLR_DN)) begin
            clr_done = cmd_mask(cmd);
        end
    end

endmodule

// File: rtl/dma_irq_status_bank.sv
module dma_irq_status_bank
    import dma_stat_pkg::*;
#(
    parameter int unsigned NUM_CH = 64,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] done_evt,
    input  logic [NUM_CH-1:0] done_irq_en,
    output logic [NUM_CH-1:0] irq_req,
    output logic [NUM_CH-1:0] done_status
);

    localparam int unsigned NUM_WORDS = NUM_CH / WORD_W;
    localparam int unsigned CLR_IRQ   = NUM_WORDS * 4;
    localparam int unsigned CLR_DN    = CLR_IRQ + 1;

    logic [NUM_CH-1:0] clr_irq, clr_done;
    logic [NUM_CH-1:0] irq_flags, done_flags;

    dma_stat_wdecode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .CLR_IRQ(CLR_IRQ),
        .CLR_DN (CLR_DN)
    ) u_dec (
        .wr_en   (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .clr_irq (clr_irq),
        .clr_done(clr_done)
    );

    dma_stat_flags #(.N(NUM_CH)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (done_evt & done_irq_en),
        .clr_i  (clr_irq),
        .flags_o(irq_flags)
    );

    dma_stat_flags #(.N(NUM_CH)) u_done (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (done_evt),
        .clr_i  (clr_done),
        .flags_o(done_flags)
    );

    // Zero-wait read path; command bytes and holes return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            for (int w = 0; w < int'(NUM_WORDS); w++) begin
                if (bus_addr == ADDR_W'((int'(NUM_WORDS) - 1 - w) * 4)) begin
                    bus_rdata = irq_flags[w*WORD_W +: WORD_W];
                end
            end
        end
    end

    assign irq_req     = irq_flags;
    assign done_status = done_flags;

endmodule

// File: rtl/dma_stat_chk.sv
module dma_stat_chk #(
    parameter int unsigned NUM_CH = 64,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic [NUM_CH-1:0] done_evt,
    input logic [NUM_CH-1:0] done_irq_en,
    input logic [NUM_CH-1:0] irq_req,
    input logic [NUM_CH-1:0] done_status
);

    localparam int unsigned NUM_WORDS = NUM_CH / 32;
    localparam int unsigned CLR_IRQ   = NUM_WORDS * 4;

    assert_reset_R8: assert property (@(posedge clk)
        !rst_n |=> (irq_req == '0 && done_status == '0));

    assert_cmd_rdzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == ADDR_W'(CLR_IRQ) || bus_addr == ADDR_W'(CLR_IRQ + 1)))
        |-> bus_rdata == '0);

    assert_hi_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == '0) |-> bus_rdata == irq_req[NUM_CH-1 -: 32]);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int unsigned WI = i / 32;
        localparam int unsigned BI = i % 32;
        localparam logic [ADDR_W-1:0] OFS = ADDR_W'((NUM_WORDS - 1 - WI) * 4);

        assert_irq_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (done_evt[i] && done_irq_en[i]) |=> irq_req[i]);

        assert_done_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            done_evt[i] |=> done_status[i]);

        assert_irq_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_req[i]) |-> $past(done_evt[i] && done_irq_en[i]));

        assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq_req[i]) |-> $past(bus_wr));

        assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(done_status[i]) |-> $past(bus_wr));

        assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == OFS && bus_wdata[BI] && !done_evt[i]) |=> !irq_req[i]);
    end

endmodule

bind dma_irq_status_bank dma_stat_chk #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_rdata  (bus_rdata),
    .done_evt   (done_evt),
    .done_irq_en(done_irq_en),
    .irq_req    (irq_req),
    .done_status(done_status)
);

// File: tb/tb_dma_irq_status_bank.sv
`timescale 1ns/1ps
module tb_dma_irq_status_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] done_evt = '0;
    logic [63:0] done_irq_en = '0;
    logic [63:0] irq_req;
    logic [63:0] done_status;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [63:0] m_irq = '0;
    logic [63:0] m_done = '0;

    always #10 clk = ~clk;

    dma_irq_status_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .done_evt(done_evt), .done_irq_en(done_irq_en),
        .irq_req(irq_req), .done_status(done_status)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Command byte: bit 7 no-op, bits 6:0 channel; 64..127 means all.
    function automatic logic [63:0] cmd_mask(input logic [7:0] b);
        logic [63:0] m;
        m = '0;
        if (!b[7]) begin
            if (b[6:0] >= 7'd64) m = '1;
            else m[b[5:0]] = 1'b1;
        end
        return m;
    endfunction

    // One clock with optional write plus completion inputs; model updated.
    task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [63:0] evt, input logic [63:0] en);
        logic [63:0] ci, cd;
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d; done_evt = evt; done_irq_en = en;
        @(negedge clk);
        bus_wr = 1'b0; done_evt = '0; done_irq_en = '0;
        ci = '0; cd = '0;
        if (wr) begin
            case (a)
                8'h00: ci = {d, 32'h0};
                8'h04: ci = {32'h0, d};
                8'h08: ci = cmd_mask(d[7:0]);
                8'h09: cd = cmd_mask(d[7:0]);
                default: ;
            endcase
        end
        m_irq  = (m_irq & ~ci) | (evt & en);
        m_done = (m_done & ~cd) | evt;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic state(input string tag);
        chk({tag, " irq_req"}, irq_req, m_irq);
        chk({tag, " done"}, done_status, m_done);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R8: reset state
        state("R8 reset");
        rd(8'h00, v); chk("R8 hi word", {32'h0, v}, 64'h0);
        rd(8'h04, v); chk("R8 lo word", {32'h0, v}, 64'h0);
        rst_n = 1'b1;

        // R1/R2/R4/R6: one-hot sweep of every channel
        for (int c = 0; c < 64; c++) begin
            logic [63:0] oh;
            oh = 64'h1 << c;
            step(1'b0, 8'h00, 32'h0, oh, oh);
            state("R2 set");
            rd(8'h00, v); chk("R1 hi map", {32'h0, v}, {32'h0, m_irq[63:32]});
            rd(8'h04, v); chk("R1 lo map", {32'h0, v}, {32'h0, m_irq[31:0]});
            step(1'b1, 8'h08, {25'h0, 7'(c)}, '0, '0);
            state("R4 single clear");
            step(1'b1, 8'h09, {25'h0, 7'(c)}, '0, '0);
            state("R6 done clear");
        end

        // R2/R10: completion with interrupt disabled sets only done
        step(1'b0, 8'h00, 32'h0, 64'hF0F0_0000_0000_0F0F, 64'h0);
        state("R10 done only");
        step(1'b1, 8'h09, 32'h0000_0040, '0, '0);
        state("R5 done all");

        // R3: bitmap clear patterns
        step(1'b0, 8'h00, 32'h0, '1, '1);
        state("R2 set all");
        step(1'b1, 8'h00, 32'hA5A5_0F0F, '0, '0);
        state("R3 hi pattern");
        step(1'b1, 8'h04, 32'h0000_0000, '0, '0);
        state("R3 zero write");
        step(1'b1, 8'h04, 32'hFFFF_0000, '0, '0);
        state("R3 lo half");
        rd(8'h04, v); chk("R3 lo readback", {32'h0, v}, {32'h0, m_irq[31:0]});

        // R4: no-op bit
        step(1'b1, 8'h08, 32'h0000_0085, '0, '0);
        state("R4 nop");
        step(1'b1, 8'h08, 32'h0000_00C0, '0, '0);
        state("R4 nop with all");
        step(1'b1, 8'h08, 32'h0000_00FF, '0, '0);
        state("R4 nop ff");

        // R5: all-channel encodings at boundaries
        step(1'b1, 8'h08, 32'h0000_003F, '0, '0);
        state("R4 ch63");
        step(1'b1, 8'h08, 32'h0000_0064, '0, '0);
        state("R5 irq all 100");
        step(1'b0, 8'h00, 32'h0, '1, '1);
        step(1'b1, 8'h09, 32'h0000_007F, '0, '0);
        state("R5 done all 127");
        step(1'b1, 8'h08, 32'h0000_0040, '0, '0);
        state("R5 irq all 64");

        // R7: command and hole reads, hole writes
        step(1'b0, 8'h00, 32'h0, 64'h8000_0001_8000_0001, '1);
        rd(8'h08, v); chk("R7 read cmd irq", {32'h0, v}, 64'h0);
        rd(8'h09, v); chk("R7 read cmd done", {32'h0, v}, 64'h0);
        rd(8'h10, v); chk("R7 read hole", {32'h0, v}, 64'h0);
        step(1'b1, 8'h10, 32'hFFFF_FFFF, '0, '0);
        state("R7 hole write");
        step(1'b1, 8'h0C, 32'hFFFF_FFFF, '0, '0);
        state("R7 hole write 0c");

        // R9: same-cycle set and clear
        step(1'b1, 8'h08, 32'h0000_0000, 64'h1, 64'h1);
        chk("R9 cmd collide", {63'h0, irq_req[0]}, 64'h1);
        state("R9 cmd collide state");
        step(1'b1, 8'h00, 32'hFFFF_FFFF, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);
        state("R9 w1c collide");
        step(1'b1, 8'h09, 32'h0000_0040, 64'h2, 64'h0);
        state("R9 done collide");

        // R10: hold while idle
        repeat (5) step(1'b0, 8'h00, 32'h0, '0, '0);
        state("R10 hold");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule